// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block collects 24 interrupt request sources, sorts them onto 10 vectors and tells the CPU which vector to enter next. Each vector has a configurable rank taken from three levels: low, high and highest. The block keeps the rank of the routine that is being serviced and only offers a request that outranks it, so routines nest. Each source has its own enable bit. A source request is a one-cycle pulse. The block latches it as pending until the CPU takes the vector that reports it.

The CPU side is a valid/ready stream. When the block has a winner it raises `irq_valid` with the vector address, the level and a flag list of the contributing sources. That payload stays frozen until the CPU takes it by holding `irq_ready` high on a clock edge. Back-pressure is unlimited: while `irq_ready` stays low nothing in the payload changes, even if a higher-ranked request arrives. That request is offered after the current one has been taken. A one-cycle `irq_ret` pulse ends the current routine. It restores the level that was interrupted, which is kept on a small internal stack.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0, `cur_level` is 0 (none) and no source is pending.
- R2: A one-cycle pulse on an enabled source, driven before clock edge k, sets the source pending at edge k. The source's vector is offered after edge k+1 and not before. The vector address is 0x03 + 8*v for vector index v.
- R3: Levels are encoded 0 = none, 1 = low, 2 = high, 3 = highest. `vec_hi[v]` = 0 gives low. `vec_hi[v]` = 1 gives highest for vectors 0 and 1, and high for vectors 2 to 9.
- R4: When several vectors are eligible, the one with the highest level is offered. Among equal levels the lowest vector index (lowest address) is offered.
- R5: A vector is offered only if its level is strictly above `cur_level`. Taking a vector sets `cur_level` to its level.
- R6: Each take saves the previous `cur_level` on a stack. Each `irq_ret` pulse restores the saved level. Held-off requests are then offered if they outrank the restored level.
- R7: A source whose `src_en` bit is 0 never causes or appears in an offer. Its pending state is kept, and setting the enable bit later lets it be offered.
- R8: `irq_flags` bit s is 1 exactly for the enabled, pending sources s of the offered vector. The sources map to vectors as follows: v0={0}, v1={1}, v2={2..5}, v3={6..9}, v4={10}, v5={11,12}, v6={13,14}, v7={15,16}, v8={17,18,19}, v9={20..23}.
- R9: While `irq_valid`=1 and `irq_ready`=0, the address, level and flags hold still. After a take, `irq_valid` is 0 for at least one cycle. A take clears only the sources listed in the taken flags. A source that became pending after the offer was made stays pending.
- R10: `irq_ret` with an empty stack leaves `cur_level` unchanged. When a take and `irq_ret` fall in the same cycle, the take is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 24 | Source request pulses, one bit per source |
| src_en | input | 24 | Per-source enable |
| vec_hi | input | 10 | Per-vector rank select (0 = low) |
| irq_valid | output | 1 | A vector is offered to the CPU |
| irq_ready | input | 1 | CPU takes the offered vector |
| irq_vaddr | output | 8 | Offered vector address |
| irq_level | output | 2 | Level of the offered vector |
| irq_flags | output | 24 | Sources that caused the offered vector |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| cur_level | output | 2 | Level currently in service |

## Verification
A source pulse driven before edge k shows up as an offer only after edge k+1. A change of enable or rank bits needs one edge. After a take, `irq_valid` is low right after the take edge, and the next offer is due at the earliest two edges after the take. `cur_level` follows a take or return one edge later. The bench drives every input on the falling edge and counts rising edges to exactly those points. It samples on the following falling edge and also checks the early sample for the source pulse latency. Expected vectors, levels and flags come from a bench-side model of pending sources and rank rules.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_SRC  = 24;
  localparam int NUM_VEC  = 10;
  localparam int NUM_XVEC = 2;
  localparam int ADDR_W   = 8;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int VIDX_W   = $clog2(NUM_VEC);

  typedef logic [1:0] lvl_t;
  localparam lvl_t LV_NONE = 2'd0;
  localparam lvl_t LV_L    = 2'd1;
  localparam lvl_t LV_H    = 2'd2;
  localparam lvl_t LV_X    = 2'd3;

  // number of sources grouped on each vector, in vector order
  localparam int GRP_SIZE [NUM_VEC] = '{1, 1, 4, 4, 1, 2, 2, 2, 3, 4};

  function automatic logic [NUM_SRC-1:0] grp_mask(input int v);
    int first;
    logic [NUM_SRC-1:0] m;
    first = 0;
    for (int i = 0; i < NUM_VEC; i++)
      if (i < v) first += GRP_SIZE[i];
    m = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (v >= 0 && v < NUM_VEC)
        if (s >= first && s < first + GRP_SIZE[v]) m[s] = 1'b1;
    return m;
  endfunction

  function automatic lvl_t rank_of(input int v, input logic hi);
    if (!hi) return LV_L;
    return (v < NUM_XVEC) ? LV_X : LV_H;
  endfunction

  function automatic logic [ADDR_W-1:0] vaddr_of(input int v);
    return ADDR_W'(VEC_BASE + v * VEC_STEP);
  endfunction
endpackage

// File: rtl/pic_src_latch.sv
module pic_src_latch
  import pic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_VEC-1:0] vec_req
);
  logic [NUM_SRC-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_eff) | src_req;
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam logic [NUM_SRC-1:0] GMASK = grp_mask(v);
    assign vec_req[v] = |(pend & src_en & GMASK);
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> (($past(pend) & ~pend) == '0)); // R9
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  logic [NUM_VEC-1:0] vec_req,
  input  logic [NUM_VEC-1:0] vec_hi,
  input  lvl_t               floor_lvl,
  output logic               found,
  output logic [VIDX_W-1:0]  win_idx,
  output lvl_t               win_lvl
);
  lvl_t rank [NUM_VEC];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_rank
    if (v < NUM_XVEC) begin : g_x
      assign rank[v] = vec_hi[v] ? LV_X : LV_L;
    end else begin : g_h
      assign rank[v] = vec_hi[v] ? LV_H : LV_L;
    end
  end

  // ascending scan with strict compare keeps the lowest index on a tie
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = floor_lvl;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (vec_req[v] && (rank[v] > win_lvl)) begin
        found   = 1'b1;
        win_idx = VIDX_W'(v);
        win_lvl = rank[v];
      end
    end
  end
endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack
  import pic_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  lvl_t enter_lvl,
  input  logic leave,
  output lvl_t cur_lvl
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  lvl_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_m1;

  assign cnt_m1 = cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_lvl <= LV_NONE;
      for (int i = 0; i < DEPTH; i++) mem[i] <= LV_NONE;
    end else if (enter) begin
      if (cnt < CNT_W'(DEPTH)) begin
        mem[cnt[IDX_W-1:0]] <= cur_lvl;
        cnt <= cnt + 1'b1;
      end
      cur_lvl <= enter_lvl;
    end else if (leave && (cnt != '0)) begin
      cur_lvl <= mem[cnt_m1[IDX_W-1:0]];
      cnt     <= cnt_m1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> (cnt < CNT_W'(DEPTH))); // R6
  AST_LEVEL_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (cur_lvl > $past(cur_lvl))); // R5
  AST_EMPTY_RET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (leave && !enter && cnt == '0) |=> $stable(cur_lvl)); // R10
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int STACK_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_VEC-1:0] vec_hi,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [ADDR_W-1:0]  irq_vaddr,
  output logic [1:0]         irq_level,
  output logic [NUM_SRC-1:0] irq_flags,
  input  logic               irq_ret,
  output logic [1:0]         cur_level
);
  localparam logic [ADDR_W-1:0] FIRST_SHARED = ADDR_W'(VEC_BASE + NUM_XVEC * VEC_STEP);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_VEC-1:0] vec_req;
  logic               found;
  logic [VIDX_W-1:0]  win_idx;
  lvl_t               win_lvl;
  lvl_t               cur_lvl;
  logic               take;
  logic [NUM_SRC-1:0] cand_flags;

  assign take      = irq_valid & irq_ready;
  assign cur_level = cur_lvl;

  pic_src_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .src_en   (src_en),
    .clr_en   (take),
    .clr_bits (irq_flags),
    .pend     (pend),
    .vec_req  (vec_req)
  );

  pic_arbiter u_arb (
    .vec_req   (vec_req),
    .vec_hi    (vec_hi),
    .floor_lvl (cur_lvl),
    .found     (found),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  pic_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter     (take),
    .enter_lvl (irq_level),
    .leave     (irq_ret),
    .cur_lvl   (cur_lvl)
  );

  assign cand_flags = pend & src_en & grp_mask(int'(win_idx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vaddr <= '0;
      irq_level <= LV_NONE;
      irq_flags <= '0;
    end else if (take) begin
      irq_valid <= 1'b0;
    end else if (!irq_valid && found) begin
      irq_valid <= 1'b1;
      irq_vaddr <= vaddr_of(int'(win_idx));
      irq_level <= win_lvl;
      irq_flags <= cand_flags;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vaddr)
      && $stable(irq_level) && $stable(irq_flags))); // R9
  AST_GAP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irq_valid); // R9
  AST_STRICT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level > cur_level)); // R5
  AST_HIGH_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level == LV_H) |-> (irq_vaddr >= FIRST_SHARED)); // R3
  AST_TOP_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_level == LV_X) |-> (irq_vaddr < FIRST_SHARED)); // R3
  AST_FLAGS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_flags != '0)); // R8
  AST_MASKED_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> ((irq_flags & ~$past(src_en)) == '0)); // R7
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] src_req, src_en;
  logic [9:0]  vec_hi;
  logic        irq_valid, irq_ready, irq_ret;
  logic [7:0]  irq_vaddr;
  logic [1:0]  irq_level, cur_level;
  logic [23:0] irq_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] m_pend;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .vec_hi(vec_hi), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vaddr(irq_vaddr), .irq_level(irq_level), .irq_flags(irq_flags),
    .irq_ret(irq_ret), .cur_level(cur_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int vec_of(input int s);
    if (s < 1)  return 0;
    if (s < 2)  return 1;
    if (s < 6)  return 2;
    if (s < 10) return 3;
    if (s < 11) return 4;
    if (s < 13) return 5;
    if (s < 15) return 6;
    if (s < 17) return 7;
    if (s < 20) return 8;
    return 9;
  endfunction

  function automatic logic [23:0] gmask(input int v);
    logic [23:0] m = '0;
    for (int s = 0; s < 24; s++) if (vec_of(s) == v) m[s] = 1'b1;
    return m;
  endfunction

  function automatic int lvl_of(input int v, input logic hi);
    if (!hi) return 1;
    return (v < 2) ? 3 : 2;
  endfunction

  function automatic void pick(input logic [23:0] p, input logic [23:0] en,
                               input logic [9:0] hi, input int cur,
                               output int idx, output int lv);
    idx = -1;
    lv  = cur;
    for (int v = 0; v < 10; v++)
      if (|(p & en & gmask(v)) && lvl_of(v, hi[v]) > lv) begin
        idx = v;
        lv  = lvl_of(v, hi[v]);
      end
  endfunction

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [23:0] bits);
    src_req = bits;
    step(1);
    src_req = '0;
    step(1);
  endtask

  task automatic take();
    irq_ready = 1'b1; step(1); irq_ready = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; step(1); irq_ret = 1'b0;
  endtask

  task automatic drain(input string tag);
    int idx, lv;
    logic [23:0] ef;
    for (int k = 0; k < 12; k++) begin
      pick(m_pend, src_en, vec_hi, 0, idx, lv);
      if (idx < 0) begin
        chk({tag, " R7 R4 nothing offered"}, irq_valid, 0);
        break;
      end
      ef = m_pend & src_en & gmask(idx);
      chk({tag, " R4 valid"}, irq_valid, 1);
      chk({tag, " R4 vaddr"}, irq_vaddr, 3 + 8 * idx);
      chk({tag, " R3 level"}, irq_level, lv);
      chk({tag, " R8 flags"}, irq_flags, ef);
      m_pend &= ~ef;
      take();
      ret();
      step(1);
    end
    chk({tag, " R6 level back to none"}, cur_level, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; src_req = '0; src_en = '1; vec_hi = '0;
    irq_ready = 1'b0; irq_ret = 1'b0;
    m_pend = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 valid after reset", irq_valid, 0);
    chk("R1 level after reset", cur_level, 0);

    // R2 latency: source 10 on vector 4
    src_req = 24'(1) << 10;
    step(1);
    src_req = '0;
    chk("R2 no offer one edge after pulse", irq_valid, 0);
    step(1);
    chk("R2 offer two edges after pulse", irq_valid, 1);
    chk("R2 vaddr of vector 4", irq_vaddr, 8'h23);
    chk("R3 low rank", irq_level, 1);
    take();
    chk("R9 valid drops after take", irq_valid, 0);
    chk("R5 level set by take", cur_level, 1);
    ret();
    chk("R6 level restored", cur_level, 0);
    step(1);
    chk("R9 taken source cleared", irq_valid, 0);

    // R4/R5/R6: vectors 4,5 high, vector 1 low
    vec_hi = 10'b00_0011_0000;
    pulse((24'(1) << 10) | (24'(1) << 11) | (24'(1) << 1));
    chk("R4 tie to lowest vector", irq_vaddr, 8'h23);
    chk("R3 high rank", irq_level, 2);
    take();
    step(2);
    chk("R5 equal level held off", irq_valid, 0);
    chk("R5 current level high", cur_level, 2);
    vec_hi[0] = 1'b1;
    pulse(24'(1));
    chk("R5 preemption offered", irq_valid, 1);
    chk("R3 top rank on vector 0", irq_level, 3);
    chk("R3 vaddr vector 0", irq_vaddr, 8'h03);
    take();
    chk("R5 current level top", cur_level, 3);
    ret();
    chk("R6 restore to high", cur_level, 2);
    step(1);
    chk("R6 high still holds vector 5", irq_valid, 0);
    ret();
    chk("R6 restore to none", cur_level, 0);
    step(1);
    chk("R4 high beats low", irq_vaddr, 8'h2B);
    chk("R6 held request offered", irq_valid, 1);
    take(); ret(); step(1);
    chk("R4 remaining low vector", irq_vaddr, 8'h0B);
    chk("R3 low level vector 1", irq_level, 1);
    take(); ret(); step(1);
    chk("R4 all drained", irq_valid, 0);
    ret();
    chk("R10 return on empty stack", cur_level, 0);

    // R7 mask
    vec_hi = '0;
    src_en[20] = 1'b0;
    pulse(24'(1) << 20);
    step(1);
    chk("R7 masked source silent", irq_valid, 0);
    src_en[20] = 1'b1;
    step(2);
    chk("R7 unmasked source offered", irq_vaddr, 8'h4B);
    chk("R8 flags of vector 9", irq_flags, 24'(1) << 20);

    // R9 hold under back-pressure, higher request arrives
    vec_hi[0] = 1'b1;
    pulse(24'(1));
    step(1);
    chk("R9 vaddr held", irq_vaddr, 8'h4B);
    chk("R9 flags held", irq_flags, 24'(1) << 20);
    take();
    chk("R9 gap after take", irq_valid, 0);
    step(1);
    chk("R5 top preempts low", irq_vaddr, 8'h03);
    irq_ready = 1'b1; irq_ret = 1'b1;
    step(1);
    irq_ready = 1'b0; irq_ret = 1'b0;
    chk("R10 take wins over return", cur_level, 3);
    ret();
    chk("R10 restore after double", cur_level, 1);
    ret();
    chk("R6 back to none", cur_level, 0);

    // R8 flags and partial clear
    vec_hi = '0;
    pulse((24'(1) << 6) | (24'(1) << 8));
    chk("R8 vaddr vector 3", irq_vaddr, 8'h1B);
    chk("R8 two flags", irq_flags, (24'(1) << 6) | (24'(1) << 8));
    pulse(24'(1) << 7);
    chk("R9 late source not merged", irq_flags, (24'(1) << 6) | (24'(1) << 8));
    take(); ret(); step(1);
    chk("R9 late source still pending", irq_valid, 1);
    chk("R8 flag of late source", irq_flags, 24'(1) << 7);
    take(); ret(); step(1);
    chk("R9 drained", irq_valid, 0);

    // random phase
    m_pend = '0;
    for (int it = 0; it < 40; it++) begin
      logic [23:0] bits;
      src_en = 24'($urandom | $urandom);
      vec_hi = 10'($urandom);
      step(2);
      drain("rnd-en");
      bits = 24'($urandom & $urandom);
      m_pend |= bits;
      pulse(bits);
      drain("rnd");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule